// File: doc/BRIEF.md
# Translation Response Fan-out

This block sits below a translation request merger. Requests that share a virtual page are enrolled into an outstanding-page table, one member record per original request: the member's low virtual-address bits, the requester port it came in on, and whether it was a prefetch. When the single translation for that page comes back, the block looks up the group by its page key. It then emits one response per member, one per cycle, in enrolment order.

Each member's physical address is rebuilt from the returned physical address. Low bits are cleared according to the returned page size, and the member's own offset is merged back in. Every member response carries the returned uncacheable bit and hit level. Each response is steered to the member's recorded port and marks whether the member's per-level request count must be popped.

The table entry is released with the last response's handshake, so it becomes free at the clock edge that ends that cycle. A probe port lets an issue scan ask whether a page is still outstanding.

Top module: `xlat_fanout`

## Requirements
- R1: A member's `out_pa` equals `rsp_pa` with its low `rsp_shift` bits cleared, OR-ed with the member's enrolled offset masked to those same low `rsp_shift` bits. `rsp_shift` is log2 of the page size in bytes, from 12 up to the offset width.
- R2: Members of one group leave in enrolment order, each with its own offset, so members of the same group differ only in their offset bits.
- R3: When `rsp_uc` is 1, every member response of that group shows `out_uc` = 1; when it is 0, every one shows 0.
- R4: Every member response carries `out_hit_lvl` equal to the `rsp_hit_lvl` of its group.
- R5: Every member response carries `out_port` equal to the port value enrolled with that member.
- R6: `out_pop` is 1 for a member enrolled with `enr_pref` = 0 and 0 for a prefetch member.
- R7: One response leaves per cycle in which `out_valid` and `out_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, the response fields hold steady into the next cycle.
- R8: `rsp_ready` is 0 for as long as a group is draining. A new translation result is accepted only after the last member of the previous group has been handed off.
- R9: A result whose key has no live table entry produces no response. Instead `err_drop` is 1 for exactly the one cycle after the result is accepted.
- R10: During the cycle of the last member's handshake, `probe_hit` for the group's key is still 1. From the next cycle on it is 0, and a later result with that key is treated as a miss (R9).
- R11: After reset, no key is live. Enrolling a new key allocates a free entry, and enrolling a live key appends a member. `enr_ready` is 0 when that key's entry already holds `MAX_MEMBERS` members, or when the key is new and every entry is live.
- R12: After reset, `out_valid` = 0, `rsp_ready` = 1, `err_drop` = 0 and `enr_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enr_valid | input | 1 | Enrol a member record |
| enr_key | input | KEY_W | Virtual page key of the member |
| enr_off | input | OFF_W | Member's low virtual-address bits |
| enr_port | input | PORT_W | Requester port of the member |
| enr_pref | input | 1 | Member is a prefetch |
| enr_ready | output | 1 | Enrolment can be taken this cycle |
| rsp_valid | input | 1 | Translation result valid |
| rsp_ready | output | 1 | Block can take a translation result |
| rsp_key | input | KEY_W | Virtual page key of the result |
| rsp_pa | input | PA_W | Returned physical address |
| rsp_shift | input | SH_W | log2 of the returned page size |
| rsp_uc | input | 1 | Returned page is uncacheable |
| rsp_hit_lvl | input | HIT_W | Level that produced the translation |
| probe_key | input | KEY_W | Page key asked about by an issue scan |
| probe_hit | output | 1 | probe_key has a live entry |
| out_valid | output | 1 | Member response valid |
| out_ready | input | 1 | Receiver takes the member response |
| out_pa | output | PA_W | Rebuilt physical address of the member |
| out_port | output | PORT_W | Port to steer the response to |
| out_uc | output | 1 | Uncacheable flag |
| out_hit_lvl | output | HIT_W | Hit level copied from the result |
| out_pop | output | 1 | Pop the member's per-level request count |
| err_drop | output | 1 | Result dropped because its key was not live |

## Verification
The main path is tried with three page sizes: 4 KiB, 64 KiB and 2 MiB. Member offsets carry ones above the page boundary and bits right at it, which tells a correct size mask from one fixed at a single page size.

Groups of one, two, three and four members, mixing prefetch and demand members and distinct ports, show whether fields are taken per member or per group. Two groups are live at once and answered in reverse order, which separates keyed lookup from first-entry selection. One group drains under irregular back-pressure, which exposes slips in hold and order.

Results for a never-enrolled key and for a key just freed tell a missing lookup from a late or absent release. Filling a group and filling the table show the two refusal cases of enrolment.

// File: rtl/xlat_fanout_pkg.sv
package xlat_fanout_pkg;

  typedef enum logic {ST_IDLE = 1'b0, ST_DRAIN = 1'b1} fan_state_t;

  // Page base: clear the low 'sh' bits of the returned physical address.
  function automatic logic [63:0] page_base(input logic [63:0] pa, input logic [4:0] sh);
    return pa & ~((64'd1 << sh) - 64'd1);
  endfunction

  // Member address: page base merged with the member's own in-page offset.
  function automatic logic [63:0] member_pa(input logic [63:0] base, input logic [63:0] off,
                                            input logic [4:0] sh);
    return base | (off & ((64'd1 << sh) - 64'd1));
  endfunction

endpackage

// File: rtl/xlat_fanout_table.sv
module xlat_fanout_table #(
  parameter int ENTRIES     = 4,
  parameter int MAX_MEMBERS = 4,
  parameter int KEY_W       = 28,
  parameter int OFF_W       = 21,
  parameter int PORT_W      = 2,
  localparam int ENT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int SLOT_W = (MAX_MEMBERS > 1) ? $clog2(MAX_MEMBERS) : 1,
  localparam int CNT_W  = $clog2(MAX_MEMBERS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enr_valid,
  input  logic [KEY_W-1:0]  enr_key,
  input  logic [OFF_W-1:0]  enr_off,
  input  logic [PORT_W-1:0] enr_port,
  input  logic              enr_pref,
  output logic              enr_ready,
  input  logic [KEY_W-1:0]  lk_key,
  output logic              lk_hit,
  output logic [ENT_W-1:0]  lk_ent,
  input  logic [KEY_W-1:0]  probe_key,
  output logic              probe_hit,
  input  logic [ENT_W-1:0]  rd_ent,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [OFF_W-1:0]  rd_off,
  output logic [PORT_W-1:0] rd_port,
  output logic              rd_pref,
  output logic [CNT_W-1:0]  rd_cnt,
  input  logic              lock_valid,
  input  logic [ENT_W-1:0]  lock_ent,
  input  logic              free_valid,
  input  logic [ENT_W-1:0]  free_ent
);

  logic [ENTRIES-1:0] live_q;
  logic [CNT_W-1:0]   cnt_q  [ENTRIES];
  logic [KEY_W-1:0]   key_q  [ENTRIES];
  logic [OFF_W-1:0]   off_q  [ENTRIES][MAX_MEMBERS];
  logic [PORT_W-1:0]  port_q [ENTRIES][MAX_MEMBERS];
  logic               pref_q [ENTRIES][MAX_MEMBERS];

  logic [ENTRIES-1:0] enr_match, lk_match, pr_match, free_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign enr_match[g] = live_q[g] && (key_q[g] == enr_key);
    assign lk_match[g]  = live_q[g] && (key_q[g] == lk_key);
    assign pr_match[g]  = live_q[g] && (key_q[g] == probe_key);
    assign free_vec[g]  = !live_q[g];
  end

  function automatic logic [ENT_W-1:0] first_set(input logic [ENTRIES-1:0] v);
    logic [ENT_W-1:0] idx;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) if (v[i]) idx = ENT_W'(i);
    return idx;
  endfunction

  logic             e_hit, enr_fire;
  logic [ENT_W-1:0] e_ent, f_ent, wr_ent;
  logic [SLOT_W-1:0] wr_slot;

  assign e_hit     = |enr_match;
  assign e_ent     = first_set(enr_match);
  assign f_ent     = first_set(free_vec);
  assign enr_ready = e_hit ? ((cnt_q[e_ent] < CNT_W'(MAX_MEMBERS)) && !(lock_valid && lock_ent == e_ent))
                           : (|free_vec);
  assign enr_fire  = enr_valid && enr_ready;
  assign wr_ent    = e_hit ? e_ent : f_ent;
  assign wr_slot   = e_hit ? SLOT_W'(cnt_q[e_ent]) : '0;

  assign lk_hit    = |lk_match;
  assign lk_ent    = first_set(lk_match);
  assign probe_hit = |pr_match;

  assign rd_off  = off_q[rd_ent][rd_slot];
  assign rd_port = port_q[rd_ent][rd_slot];
  assign rd_pref = pref_q[rd_ent][rd_slot];
  assign rd_cnt  = cnt_q[rd_ent];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
      for (int i = 0; i < ENTRIES; i++) cnt_q[i] <= '0;
    end else begin
      if (free_valid) live_q[free_ent] <= 1'b0;
      if (enr_fire) begin
        if (e_hit) begin
          cnt_q[e_ent] <= cnt_q[e_ent] + CNT_W'(1);
        end else begin
          live_q[f_ent] <= 1'b1;
          cnt_q[f_ent]  <= CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (enr_fire) begin
      if (!e_hit) key_q[f_ent] <= enr_key;
      off_q[wr_ent][wr_slot]  <= enr_off;
      port_q[wr_ent][wr_slot] <= enr_port;
      pref_q[wr_ent][wr_slot] <= enr_pref;
    end
  end

endmodule

// File: rtl/xlat_fanout_seq.sv
module xlat_fanout_seq
  import xlat_fanout_pkg::*;
#(
  parameter int ENTRIES     = 4,
  parameter int MAX_MEMBERS = 4,
  parameter int PA_W        = 40,
  parameter int OFF_W       = 21,
  parameter int SH_W        = 5,
  parameter int HIT_W       = 2,
  parameter int PORT_W      = 2,
  localparam int ENT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int SLOT_W = (MAX_MEMBERS > 1) ? $clog2(MAX_MEMBERS) : 1,
  localparam int CNT_W  = $clog2(MAX_MEMBERS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [PA_W-1:0]   rsp_pa,
  input  logic [SH_W-1:0]   rsp_shift,
  input  logic              rsp_uc,
  input  logic [HIT_W-1:0]  rsp_hit_lvl,
  input  logic              lk_hit,
  input  logic [ENT_W-1:0]  lk_ent,
  output logic [ENT_W-1:0]  rd_ent,
  output logic [SLOT_W-1:0] rd_slot,
  input  logic [OFF_W-1:0]  rd_off,
  input  logic [PORT_W-1:0] rd_port,
  input  logic              rd_pref,
  input  logic [CNT_W-1:0]  rd_cnt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PA_W-1:0]   out_pa,
  output logic [PORT_W-1:0] out_port,
  output logic              out_uc,
  output logic [HIT_W-1:0]  out_hit_lvl,
  output logic              out_pop,
  output logic              err_drop,
  output logic              accept,
  output logic              beat_fire,
  output logic              group_done,
  output logic              lock_valid,
  output logic [ENT_W-1:0]  lock_ent
);

  fan_state_t        state_q;
  logic [ENT_W-1:0]  ent_q;
  logic [SLOT_W-1:0] slot_q;
  logic [PA_W-1:0]   base_q;
  logic [SH_W-1:0]   sh_q;
  logic              uc_q, err_q;
  logic [HIT_W-1:0]  hit_q;
  logic              last_slot;
  logic [63:0]       pa_full, base_full;

  assign rsp_ready = (state_q == ST_IDLE);
  assign accept    = rsp_valid && rsp_ready;
  assign out_valid = (state_q == ST_DRAIN);
  assign beat_fire = out_valid && out_ready;
  assign last_slot = (CNT_W'(slot_q) + CNT_W'(1)) == rd_cnt;
  assign group_done = beat_fire && last_slot;

  assign rd_ent     = ent_q;
  assign rd_slot    = slot_q;
  assign lock_valid = out_valid;
  assign lock_ent   = ent_q;

  assign base_full   = page_base(64'(rsp_pa), 5'(rsp_shift));
  assign pa_full     = member_pa(64'(base_q), 64'(rd_off), 5'(sh_q));
  assign out_pa      = pa_full[PA_W-1:0];
  assign out_port    = rd_port;
  assign out_uc      = uc_q;
  assign out_hit_lvl = hit_q;
  assign out_pop     = !rd_pref;
  assign err_drop    = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ent_q   <= '0;
      slot_q  <= '0;
      base_q  <= '0;
      sh_q    <= '0;
      uc_q    <= 1'b0;
      hit_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (accept) begin
        if (lk_hit) begin
          state_q <= ST_DRAIN;
          ent_q   <= lk_ent;
          slot_q  <= '0;
          base_q  <= base_full[PA_W-1:0];
          sh_q    <= rsp_shift;
          uc_q    <= rsp_uc;
          hit_q   <= rsp_hit_lvl;
        end else begin
          err_q <= 1'b1;
        end
      end else if (beat_fire) begin
        if (last_slot) state_q <= ST_IDLE;
        else           slot_q  <= slot_q + SLOT_W'(1);
      end
    end
  end

endmodule

// File: rtl/xlat_fanout.sv
module xlat_fanout #(
  parameter int ENTRIES     = 4,
  parameter int MAX_MEMBERS = 4,
  parameter int KEY_W       = 28,
  parameter int OFF_W       = 21,
  parameter int PA_W        = 40,
  parameter int SH_W        = 5,
  parameter int HIT_W       = 2,
  parameter int PORT_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enr_valid,
  input  logic [KEY_W-1:0]  enr_key,
  input  logic [OFF_W-1:0]  enr_off,
  input  logic [PORT_W-1:0] enr_port,
  input  logic              enr_pref,
  output logic              enr_ready,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [KEY_W-1:0]  rsp_key,
  input  logic [PA_W-1:0]   rsp_pa,
  input  logic [SH_W-1:0]   rsp_shift,
  input  logic              rsp_uc,
  input  logic [HIT_W-1:0]  rsp_hit_lvl,
  input  logic [KEY_W-1:0]  probe_key,
  output logic              probe_hit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PA_W-1:0]   out_pa,
  output logic [PORT_W-1:0] out_port,
  output logic              out_uc,
  output logic [HIT_W-1:0]  out_hit_lvl,
  output logic              out_pop,
  output logic              err_drop
);

  localparam int ENT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int SLOT_W = (MAX_MEMBERS > 1) ? $clog2(MAX_MEMBERS) : 1;
  localparam int CNT_W  = $clog2(MAX_MEMBERS + 1);

  // Internal events brought out by name for the checker.
  logic              accept, beat_fire, group_done, lock_valid, lk_hit;
  logic [ENT_W-1:0]  lk_ent, rd_ent, lock_ent;
  logic [SLOT_W-1:0] rd_slot;
  logic [OFF_W-1:0]  rd_off;
  logic [PORT_W-1:0] rd_port;
  logic              rd_pref;
  logic [CNT_W-1:0]  rd_cnt;

  xlat_fanout_table #(
    .ENTRIES(ENTRIES), .MAX_MEMBERS(MAX_MEMBERS), .KEY_W(KEY_W),
    .OFF_W(OFF_W), .PORT_W(PORT_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .enr_valid(enr_valid), .enr_key(enr_key), .enr_off(enr_off),
    .enr_port(enr_port), .enr_pref(enr_pref), .enr_ready(enr_ready),
    .lk_key(rsp_key), .lk_hit(lk_hit), .lk_ent(lk_ent),
    .probe_key(probe_key), .probe_hit(probe_hit),
    .rd_ent(rd_ent), .rd_slot(rd_slot), .rd_off(rd_off), .rd_port(rd_port),
    .rd_pref(rd_pref), .rd_cnt(rd_cnt),
    .lock_valid(lock_valid), .lock_ent(lock_ent),
    .free_valid(group_done), .free_ent(rd_ent)
  );

  xlat_fanout_seq #(
    .ENTRIES(ENTRIES), .MAX_MEMBERS(MAX_MEMBERS), .PA_W(PA_W), .OFF_W(OFF_W),
    .SH_W(SH_W), .HIT_W(HIT_W), .PORT_W(PORT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
    .rsp_shift(rsp_shift), .rsp_uc(rsp_uc), .rsp_hit_lvl(rsp_hit_lvl),
    .lk_hit(lk_hit), .lk_ent(lk_ent),
    .rd_ent(rd_ent), .rd_slot(rd_slot), .rd_off(rd_off), .rd_port(rd_port),
    .rd_pref(rd_pref), .rd_cnt(rd_cnt),
    .out_valid(out_valid), .out_ready(out_ready), .out_pa(out_pa),
    .out_port(out_port), .out_uc(out_uc), .out_hit_lvl(out_hit_lvl),
    .out_pop(out_pop), .err_drop(err_drop),
    .accept(accept), .beat_fire(beat_fire), .group_done(group_done),
    .lock_valid(lock_valid), .lock_ent(lock_ent)
  );

endmodule

// File: rtl/xlat_fanout_chk.sv
module xlat_fanout_chk #(
  parameter int PA_W   = 40,
  parameter int HIT_W  = 2,
  parameter int PORT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rsp_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PA_W-1:0]   out_pa,
  input logic [PORT_W-1:0] out_port,
  input logic              out_uc,
  input logic [HIT_W-1:0]  out_hit_lvl,
  input logic              out_pop,
  input logic              err_drop,
  input logic              accept,
  input logic              beat_fire,
  input logic              group_done
);

  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !rsp_ready); // R8

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pa) && $stable(out_port)
                                   && $stable(out_pop))); // R7

  AST_UC_SAME_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(out_uc)); // R3

  AST_HIT_SAME_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(out_hit_lvl)); // R4

  AST_ERR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    err_drop |-> ($past(accept) && !out_valid)); // R9

  AST_FREE_ON_LAST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    group_done |-> beat_fire); // R10

  AST_FREE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    group_done |=> (!out_valid && rsp_ready)); // R10

endmodule

bind xlat_fanout xlat_fanout_chk #(.PA_W(PA_W), .HIT_W(HIT_W), .PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_ready(rsp_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_pa(out_pa), .out_port(out_port), .out_uc(out_uc),
  .out_hit_lvl(out_hit_lvl), .out_pop(out_pop), .err_drop(err_drop),
  .accept(accept), .beat_fire(beat_fire), .group_done(group_done)
);

// File: tb/xlat_fanout_tb.sv
module xlat_fanout_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enr_valid = 1'b0;
  logic [27:0] enr_key = '0;
  logic [20:0] enr_off = '0;
  logic [1:0]  enr_port = '0;
  logic        enr_pref = 1'b0;
  logic        enr_ready;
  logic        rsp_valid = 1'b0;
  logic        rsp_ready;
  logic [27:0] rsp_key = '0;
  logic [39:0] rsp_pa = '0;
  logic [4:0]  rsp_shift = '0;
  logic        rsp_uc = 1'b0;
  logic [1:0]  rsp_hit_lvl = '0;
  logic [27:0] probe_key = '0;
  logic        probe_hit;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [39:0] out_pa;
  logic [1:0]  out_port;
  logic        out_uc;
  logic [1:0]  out_hit_lvl;
  logic        out_pop;
  logic        err_drop;

  xlat_fanout u_dut (
    .clk(clk), .rst_n(rst_n), .enr_valid(enr_valid), .enr_key(enr_key),
    .enr_off(enr_off), .enr_port(enr_port), .enr_pref(enr_pref), .enr_ready(enr_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_key(rsp_key), .rsp_pa(rsp_pa),
    .rsp_shift(rsp_shift), .rsp_uc(rsp_uc), .rsp_hit_lvl(rsp_hit_lvl),
    .probe_key(probe_key), .probe_hit(probe_hit), .out_valid(out_valid),
    .out_ready(out_ready), .out_pa(out_pa), .out_port(out_port), .out_uc(out_uc),
    .out_hit_lvl(out_hit_lvl), .out_pop(out_pop), .err_drop(err_drop)
  );

  always #10 clk = ~clk; // 50 MHz

  typedef struct packed {
    logic [39:0] pa;
    logic [1:0]  port;
    logic        uc;
    logic [1:0]  hit;
    logic        pop;
  } exp_t;

  typedef struct packed {
    logic [27:0] key;
    logic [20:0] off;
    logic [1:0]  port;
    logic        pref;
  } rec_t;

  exp_t exp_q[$];
  rec_t rec_q[$];
  int   checks = 0;
  int   failures = 0;
  bit   bp_en = 1'b0;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Back-pressure pattern, changed just after each rising edge.
  always @(posedge clk) begin
    #1 out_ready = bp_en ? (($urandom % 3) != 0) : 1'b1;
  end

  // Monitor: compares every handed-off member against the scoreboard.
  exp_t held;
  bit   prev_stall = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_stall) begin
        check(out_valid && {out_pa, out_port, out_pop} == {held.pa, held.port, held.pop},
              "R7 hold", {out_pa, out_port, out_pop}, {held.pa, held.port, held.pop});
      end
      if (out_valid) check(!rsp_ready, "R8 busy", rsp_ready, 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected member", out_pa, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(out_pa == e.pa, "R1/R2 out_pa", out_pa, e.pa);
          check(out_port == e.port, "R5 out_port", out_port, e.port);
          check(out_uc == e.uc, "R3 out_uc", out_uc, e.uc);
          check(out_hit_lvl == e.hit, "R4 out_hit_lvl", out_hit_lvl, e.hit);
          check(out_pop == e.pop, "R6 out_pop", out_pop, e.pop);
          if (exp_q.size() == 0) check(probe_hit, "R10 live on last beat", probe_hit, 1);
        end
      end
      prev_stall = out_valid && !out_ready;
      held = '{pa: out_pa, port: out_port, uc: out_uc, hit: out_hit_lvl, pop: out_pop};
    end
  end

  task automatic enrol(input logic [27:0] key, input logic [20:0] off, input logic [1:0] port,
                       input logic pref, input bit exp_rdy);
    @(negedge clk);
    enr_valid = 1'b1; enr_key = key; enr_off = off; enr_port = port; enr_pref = pref;
    #1;
    check(enr_ready == exp_rdy, "R11 enr_ready", enr_ready, exp_rdy);
    if (enr_ready) rec_q.push_back('{key: key, off: off, port: port, pref: pref});
    @(posedge clk);
    #1 enr_valid = 1'b0;
  endtask

  task automatic send_rsp(input logic [27:0] key, input logic [39:0] pa, input logic [4:0] sh,
                          input logic uc, input logic [1:0] hit);
    rec_t keep[$];
    logic [63:0] base, mask;
    mask = (64'd1 << sh) - 1;
    base = {24'd0, pa} & ~mask;
    foreach (rec_q[i]) begin
      if (rec_q[i].key == key) begin
        logic [63:0] p;
        p = base | ({43'd0, rec_q[i].off} & mask);
        exp_q.push_back('{pa: p[39:0], port: rec_q[i].port, uc: uc, hit: hit, pop: !rec_q[i].pref});
      end else begin
        keep.push_back(rec_q[i]);
      end
    end
    rec_q = keep;
    @(negedge clk);
    while (!rsp_ready) @(negedge clk);
    probe_key = key;
    rsp_valid = 1'b1; rsp_key = key; rsp_pa = pa; rsp_shift = sh; rsp_uc = uc; rsp_hit_lvl = hit;
    @(posedge clk);
    #1 rsp_valid = 1'b0;
  endtask

  task automatic wait_drain();
    @(negedge clk);
    while (exp_q.size() != 0 || out_valid) @(negedge clk);
  endtask

  task automatic miss_case(input logic [27:0] key, input string req);
    send_rsp(key, 40'hFF_0000_0000, 5'd12, 1'b0, 2'd0);
    @(negedge clk);
    check(err_drop == 1'b1, req, err_drop, 1);
    check(out_valid == 1'b0, req, out_valid, 0);
    @(negedge clk);
    check(err_drop == 1'b0, req, err_drop, 0);
  endtask

  int cyc = 0;
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000 && !done) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=50000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    probe_key = 28'h100;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check(out_valid == 0, "R12 out_valid", out_valid, 0);
    check(rsp_ready == 1, "R12 rsp_ready", rsp_ready, 1);
    check(err_drop == 0, "R12 err_drop", err_drop, 0);
    check(enr_ready == 1, "R12 enr_ready", enr_ready, 1);
    check(probe_hit == 0, "R11 empty after reset", probe_hit, 0);

    // Group A: 4 KiB page, three members, one prefetch.
    enrol(28'h100, 21'h0_0123, 2'd0, 1'b0, 1'b1);
    enrol(28'h100, 21'h1_9ABC, 2'd2, 1'b1, 1'b1);
    enrol(28'h100, 21'h0_0FFF, 2'd3, 1'b0, 1'b1);
    @(negedge clk);
    check(probe_hit == 1, "R11 allocated", probe_hit, 1);
    send_rsp(28'h100, 40'hAB_CDEF_5A5A, 5'd12, 1'b0, 2'd1);
    wait_drain();
    check(probe_hit == 0, "R10 freed after last beat", probe_hit, 0);

    // Group B: 2 MiB page, full group, uncacheable, under back-pressure.
    enrol(28'h200, 21'h1F_FFFF, 2'd1, 1'b0, 1'b1);
    enrol(28'h200, 21'h00_0001, 2'd3, 1'b1, 1'b1);
    enrol(28'h200, 21'h15_4321, 2'd0, 1'b0, 1'b1);
    enrol(28'h200, 21'h0A_BCDE, 2'd2, 1'b0, 1'b1);
    enrol(28'h200, 21'h00_0000, 2'd0, 1'b0, 1'b0); // R11 group full
    bp_en = 1'b1;
    send_rsp(28'h200, 40'h12_3456_7890, 5'd21, 1'b1, 2'd3);
    wait_drain();
    bp_en = 1'b0;

    // Groups C and D live together (64 KiB pages), answered in reverse order.
    enrol(28'h300, 21'h0_4567, 2'd2, 1'b0, 1'b1);
    enrol(28'h301, 21'h1_FEDC, 2'd1, 1'b1, 1'b1);
    enrol(28'h300, 21'h1_0010, 2'd3, 1'b0, 1'b1);
    send_rsp(28'h301, 40'h00_7777_0000, 5'd16, 1'b1, 2'd2);
    wait_drain();
    @(negedge clk);
    probe_key = 28'h300;
    #1 check(probe_hit == 1, "R10 other group untouched", probe_hit, 1);
    send_rsp(28'h300, 40'h00_1234_FFFF, 5'd16, 1'b0, 2'd0);
    wait_drain();

    // Misses: never-enrolled key, then a key just freed.
    miss_case(28'h555, "R9 unknown key");
    miss_case(28'h100, "R10 freed key misses");

    // Table exhaustion: four distinct keys fill it, a fifth is refused.
    enrol(28'h400, 21'h1, 2'd0, 1'b0, 1'b1);
    enrol(28'h401, 21'h2, 2'd1, 1'b0, 1'b1);
    enrol(28'h402, 21'h3, 2'd2, 1'b0, 1'b1);
    enrol(28'h403, 21'h4, 2'd3, 1'b0, 1'b1);
    enrol(28'h404, 21'h5, 2'd0, 1'b0, 1'b0); // R11 no free entry
    send_rsp(28'h402, 40'h55_0000_1000, 5'd12, 1'b0, 2'd1);
    wait_drain();
    enrol(28'h404, 21'h5, 2'd0, 1'b1, 1'b1); // R11 freed entry reused
    send_rsp(28'h404, 40'h66_0000_2000, 5'd12, 1'b1, 2'd3);
    wait_drain();

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule